// File: doc/BRIEF.md
# Combined Link Reset Coordinator

This block turns one global link reset input into an ordered series of requests to the two direction reset sequencers of a serial link. It does not drive any lane or PLL reset itself. It pulses the request inputs of the transmit and receive sequencers and watches their done flags. The transmit direction is always brought up before the receive direction.

The global reset input may be asynchronous. It passes through a synchronizer, and a sequence starts on the falling edge of the synchronized copy. The transmit sequencer first gets a full request, which covers its PLLs and its datapath. Once transmit reports done, the receive sequencer gets one request. The compile-time parameter `SHARED_PLL` selects which one:
- When both directions are clocked from the same PLLs, the receive side gets a datapath-only request, so the shared PLLs are not reset a second time.
- When the PLLs are separate, the receive side gets a full request.

A busy flag stays high from the start of a sequence until receive reports done. A new falling edge during a sequence aborts it and restarts from the transmit step.

Top module: `link_reset_coord`

## Requirements
- R1: While rst_ni is low, and after its release until a sequence starts, all three request outputs and busy_o are low.
- R2: A sequence starts only on a high-to-low change of reset_all_i after synchronization. tx_full_req_o rises SYNC_STAGES+1 clock edges after the first edge that samples reset_all_i low. A rising change, or holding the input high, requests nothing.
- R3: tx_full_req_o is a pulse one clock cycle wide. busy_o is high in the same cycle and stays high.
- R4: After the transmit request, a done flag that is still high from before is ignored. The receive request is issued only after tx_done_i has been sampled low and then sampled high.
- R5: With SHARED_PLL=1, the receive request appears on rx_dp_req_o, and rx_full_req_o never pulses.
- R6: With SHARED_PLL=0, the receive request appears on rx_full_req_o, and rx_dp_req_o never pulses.
- R7: The receive request is one cycle wide. It is high in the cycle after the edge that samples tx_done_i high.
- R8: busy_o stays high until rx_done_i has been sampled low and then high after the receive request. It is low from the cycle after that edge.
- R9: A new synchronized falling edge during a sequence raises tx_full_req_o again with the R2 latency. busy_o stays high throughout. No receive request is issued until the transmit handshake of R4 completes again.
- R10: At most one request output is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Control clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| reset_all_i | input | 1 | Global link reset, may be asynchronous; a sequence starts when it falls |
| tx_done_i | input | 1 | Done flag from the transmit reset sequencer |
| rx_done_i | input | 1 | Done flag from the receive reset sequencer |
| tx_full_req_o | output | 1 | One-cycle request for a transmit PLL-plus-datapath reset |
| rx_full_req_o | output | 1 | One-cycle request for a receive PLL-plus-datapath reset |
| rx_dp_req_o | output | 1 | One-cycle request for a receive datapath-only reset |
| busy_o | output | 1 | High while a sequence is in progress |

## Verification
The hardest case to reach is an abort that lands in each of the four waiting phases: after the transmit request, with tx_done_i low, after the receive request, and with rx_done_i low. Each abort has to happen while one done flag still holds a stale value. The bench drives the done flags itself in place of the sequencers. It sweeps the stale-high time, the low time and the abort phase, and raises and then drops reset_all_i at each point. Two instances, one per `SHARED_PLL` setting, receive the same stimulus, so both receive-request variants are checked on every pattern.

// File: rtl/lrc_pkg.sv
package lrc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_TX_ARM  = 3'd1,
    ST_TX_WAIT = 3'd2,
    ST_RX_ARM  = 3'd3,
    ST_RX_WAIT = 3'd4
  } lrc_state_e;
endpackage

// File: rtl/lrc_sync.sv
module lrc_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/lrc_fall_det.sv
module lrc_fall_det (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  output logic fall_o
);
  logic prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b0;
    else         prev_q <= lvl_i;
  end

  assign fall_o = prev_q & ~lvl_i;
endmodule

// File: rtl/lrc_fsm.sv
module lrc_fsm
  import lrc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic tx_done_i,
  input  logic rx_done_i,
  output logic tx_req_o,
  output logic rx_req_o,
  output logic busy_o
);
  lrc_state_e state_q, state_d;
  logic       tx_req_q, tx_req_d;
  logic       rx_req_q, rx_req_d;

  always_comb begin
    state_d  = state_q;
    tx_req_d = 1'b0;
    rx_req_d = 1'b0;
    if (start_i) begin
      // restart has priority over any phase
      state_d  = ST_TX_ARM;
      tx_req_d = 1'b1;
    end else begin
      unique case (state_q)
        ST_TX_ARM:  if (!tx_done_i) state_d = ST_TX_WAIT;
        ST_TX_WAIT: if (tx_done_i) begin
          state_d  = ST_RX_ARM;
          rx_req_d = 1'b1;
        end
        ST_RX_ARM:  if (!rx_done_i) state_d = ST_RX_WAIT;
        ST_RX_WAIT: if (rx_done_i)  state_d = ST_IDLE;
        default:    state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      tx_req_q <= 1'b0;
      rx_req_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      tx_req_q <= tx_req_d;
      rx_req_q <= rx_req_d;
    end
  end

  assign tx_req_o = tx_req_q;
  assign rx_req_o = rx_req_q;
  assign busy_o   = (state_q != ST_IDLE);
endmodule

// File: rtl/link_reset_coord.sv
module link_reset_coord #(
  parameter bit SHARED_PLL  = 1'b1,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic reset_all_i,
  input  logic tx_done_i,
  input  logic rx_done_i,
  output logic tx_full_req_o,
  output logic rx_full_req_o,
  output logic rx_dp_req_o,
  output logic busy_o
);
  logic all_sync;
  logic start;
  logic rx_req;

  lrc_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (reset_all_i),
    .q_o   (all_sync)
  );

  lrc_fall_det u_fall (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .lvl_i (all_sync),
    .fall_o(start)
  );

  lrc_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .start_i  (start),
    .tx_done_i(tx_done_i),
    .rx_done_i(rx_done_i),
    .tx_req_o (tx_full_req_o),
    .rx_req_o (rx_req),
    .busy_o   (busy_o)
  );

  generate
    if (SHARED_PLL) begin : g_shared
      assign rx_dp_req_o   = rx_req;
      assign rx_full_req_o = 1'b0;
    end else begin : g_split
      assign rx_full_req_o = rx_req;
      assign rx_dp_req_o   = 1'b0;
    end
  endgenerate
endmodule

// File: rtl/lrc_checker.sv
module lrc_checker #(
  parameter bit SHARED_PLL = 1'b1
) (
  input logic clk_i,
  input logic rst_ni,
  input logic tx_done_i,
  input logic rx_done_i,
  input logic tx_full_req_o,
  input logic rx_full_req_o,
  input logic rx_dp_req_o,
  input logic busy_o
);
  AST_RESET_QUIET: assert property (@(posedge clk_i)
    !rst_ni |-> !(tx_full_req_o || rx_full_req_o || rx_dp_req_o || busy_o)); // R1

  AST_TX_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full_req_o |=> !tx_full_req_o); // R3

  AST_TX_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_full_req_o |-> busy_o); // R3

  AST_START_WITH_TX: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> tx_full_req_o); // R2

  AST_RX_AFTER_TXDONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_req_o || rx_dp_req_o) |-> $past(tx_done_i)); // R4

  AST_RX_KIND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_req_o || rx_dp_req_o) |-> (rx_dp_req_o == SHARED_PLL)); // R5

  AST_RX_KIND_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_req_o || rx_dp_req_o) |-> (rx_full_req_o == !SHARED_PLL)); // R6

  AST_RX_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_full_req_o || rx_dp_req_o) |=> !(rx_full_req_o || rx_dp_req_o)); // R7

  AST_BUSY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> $past(rx_done_i)); // R8

  AST_ONE_REQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({tx_full_req_o, rx_full_req_o, rx_dp_req_o})); // R10
endmodule

bind link_reset_coord lrc_checker #(.SHARED_PLL(SHARED_PLL)) u_lrc_checker (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .tx_done_i    (tx_done_i),
  .rx_done_i    (rx_done_i),
  .tx_full_req_o(tx_full_req_o),
  .rx_full_req_o(rx_full_req_o),
  .rx_dp_req_o  (rx_dp_req_o),
  .busy_o       (busy_o)
);

// File: tb/link_reset_coord_bench.sv
`timescale 1ns/1ps
module link_reset_coord_bench;
  localparam int SYNC = 2;
  localparam int WDOG = 150000;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic reset_all = 1'b1;
  logic tx_done = 1'b1;
  logic rx_done = 1'b1;
  logic tx_s, rxf_s, rxd_s, busy_s;
  logic tx_n, rxf_n, rxd_n, busy_n;
  int   n_chk = 0;
  int   n_bad = 0;
  int   cyc = 0;
  bit   finished = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  link_reset_coord #(.SHARED_PLL(1'b1), .SYNC_STAGES(SYNC)) u_link_reset_coord (
    .clk_i(clk), .rst_ni(rst_ni), .reset_all_i(reset_all),
    .tx_done_i(tx_done), .rx_done_i(rx_done),
    .tx_full_req_o(tx_s), .rx_full_req_o(rxf_s), .rx_dp_req_o(rxd_s), .busy_o(busy_s));

  link_reset_coord #(.SHARED_PLL(1'b0), .SYNC_STAGES(SYNC)) u_link_reset_coord_split (
    .clk_i(clk), .rst_ni(rst_ni), .reset_all_i(reset_all),
    .tx_done_i(tx_done), .rx_done_i(rx_done),
    .tx_full_req_o(tx_n), .rx_full_req_o(rxf_n), .rx_dp_req_o(rxd_n), .busy_o(busy_n));

  task automatic chk(string r, string what, logic act, logic exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: got %b expected %b", r, what, cyc, act, exp);
    end
  endtask

  // compare both instances; exp_rx lands on dp (shared) or full (split)
  task automatic outs(string r, logic e_tx, logic e_rx, logic e_busy);
    chk(r, "tx_full shared", tx_s, e_tx);
    chk(r, "tx_full split", tx_n, e_tx);
    chk("R5", "rx_dp shared", rxd_s, e_rx);
    chk("R5", "rx_full shared", rxf_s, 1'b0);
    chk("R6", "rx_full split", rxf_n, e_rx);
    chk("R6", "rx_dp split", rxd_n, 1'b0);
    chk(r, "busy shared", busy_s, e_busy);
    chk(r, "busy split", busy_n, e_busy);
    chk("R10", "one req shared", 1'($countones({tx_s, rxf_s, rxd_s}) <= 1), 1'b1);
    chk("R10", "one req split", 1'($countones({tx_n, rxf_n, rxd_n}) <= 1), 1'b1);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // drop reset_all and expect the transmit request after SYNC+1 edges
  task automatic fall_and_expect(string r, logic busy_before);
    reset_all = 1'b0;
    for (int i = 0; i < SYNC; i++) begin
      step();
      outs(r, 1'b0, 1'b0, busy_before);
    end
    step();
    outs(r, 1'b1, 1'b0, 1'b1);          // R3 pulse with busy
    step();
    outs("R3", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic launch();
    reset_all = 1'b1;
    for (int i = 0; i < SYNC + 1; i++) begin
      step();
      outs("R2", 1'b0, 1'b0, 1'b0);     // rising/held high starts nothing
    end
    fall_and_expect("R2", 1'b0);
  endtask

  task automatic abort_seq();
    reset_all = 1'b1;
    for (int i = 0; i < SYNC + 1; i++) begin
      step();
      outs("R9", 1'b0, 1'b0, 1'b1);
    end
    fall_and_expect("R9", 1'b1);
  endtask

  task automatic tx_handshake();
    tx_done = 1'b0;
    step();
    outs("R4", 1'b0, 1'b0, 1'b1);
    tx_done = 1'b1;
    step();
    outs("R7", 1'b0, 1'b1, 1'b1);
    step();
    outs("R7", 1'b0, 1'b0, 1'b1);
  endtask

  task automatic run_seq(int a, int b, int c, int d, int ab);
    launch();
    if (ab == 1) abort_seq();
    for (int i = 0; i < a; i++) begin
      step();
      outs("R4", 1'b0, 1'b0, 1'b1);     // stale tx_done high ignored
    end
    tx_done = 1'b0;
    for (int i = 0; i < b; i++) begin
      step();
      outs("R4", 1'b0, 1'b0, 1'b1);
    end
    if (ab == 2) abort_seq();
    tx_done = 1'b1;
    step();
    outs("R7", 1'b0, 1'b1, 1'b1);
    step();
    outs("R7", 1'b0, 1'b0, 1'b1);
    if (ab == 3) begin
      abort_seq();
      tx_handshake();
    end
    for (int i = 0; i < c; i++) begin
      step();
      outs("R8", 1'b0, 1'b0, 1'b1);     // stale rx_done high ignored
    end
    rx_done = 1'b0;
    for (int i = 0; i < d; i++) begin
      step();
      outs("R8", 1'b0, 1'b0, 1'b1);
    end
    if (ab == 4) begin
      abort_seq();
      tx_handshake();
      step();
      outs("R8", 1'b0, 1'b0, 1'b1);
    end
    rx_done = 1'b1;
    step();
    outs("R8", 1'b0, 1'b0, 1'b0);
    for (int i = 0; i < 2; i++) begin
      step();
      outs("R8", 1'b0, 1'b0, 1'b0);
    end
  endtask

  initial begin : watchdog
    while (cyc < WDOG && !finished) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run hung at cycle %0d, expected completion", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : stim
    // R1: quiet during and after reset
    for (int i = 0; i < 3; i++) begin
      step();
      outs("R1", 1'b0, 1'b0, 1'b0);
    end
    rst_ni = 1'b1;
    for (int i = 0; i < 4; i++) begin
      step();
      outs("R1", 1'b0, 1'b0, 1'b0);
    end
    for (int ab = 0; ab < 5; ab++)
      for (int a = 0; a < 3; a++)
        for (int b = 1; b < 4; b++)
          for (int c = 0; c < 3; c++)
            for (int d = 1; d < 3; d++)
              run_seq(a, b, c, d, ab);
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule